// File: doc/BRIEF.md
# I/O Space Decoder with Single-Bit Operations

This block sits between an 8-bit core's execute stage and its peripheral registers. It receives access requests that have already been decoded. Each request carries an operation code, an address, write data and a bit index. The block maps every request onto one unified register space, indexed by data-space address.

Port-form accesses reach I/O addresses 0x00–0x3F. Data-space loads and stores reach the same registers at the I/O address plus 0x20, and they alone reach the extended area from data address 0x60 upward. Single-bit set, clear and test apply only to I/O addresses 0x00–0x1F.

The mapped registers are four general-purpose bytes and one status register with write-one-to-clear flags. They show two things: a bit operation never writes back the other bits of a register, and a pending flag cannot be lost through a read-modify-write.

Top module: `iosp_decoder`

## Requirements
- R1: After a synchronous, active-high reset, every general-purpose byte, every status flag and the extended byte read 0x00, and `err` is low.
- R2: Operation codes are: 0 port read, 1 port write, 2 load, 3 store, 4 bit set, 5 bit clear, 6 bit test, and 7 invalid. A port access to address A, with A from 0x00 to 0x3F, reaches I/O address A. The general-purpose bytes are at I/O 0x00–0x03 and the status register is at I/O 0x04.
- R3: A load or store to data address D, with D from 0x20 to 0x5F, reaches the same register as I/O address D−0x20.
- R4: The extended byte at data address 0x60 is a full read/write register. It is reachable only through load and store.
- R5: Bit set, clear and test are legal only for addresses 0x00–0x1F, and the address is treated as an I/O address.
- R6: A bit set or bit clear on a general-purpose byte changes only the bit selected by `req_bit`.
- R7: Status flags sit in bits [3:0] of the status register.
  - A write clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged.
  - A bit set clears only the flag it names.
  - A bit clear changes no flag.
- R8: A flag is set one cycle after its `flag_raise` bit is high. A raise in the same cycle as a clear of that flag leaves the flag set.
- R9: Status bits [7:4] always read 0. Writing them, or applying a bit operation to them, has no effect and raises no error.
- R10: During a legal bit test, `bit_flag` combinationally equals the addressed bit of the addressed register. At any other time it is 0.
- R11: The following requests are illegal:
  - a port access above 0x3F;
  - a load or store below 0x20;
  - a bit operation above 0x1F;
  - operation code 7;
  - any address with no register.
  
  A valid illegal request changes no register. It makes `err` high for exactly the following cycle. After a legal request or an idle cycle, `err` is low.
- R12: During a legal read, `rd_data` combinationally equals the addressed register. For every other request, and when idle, it is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (see R2) |
| req_addr | input | 8 | Port, data or bit-operation address |
| req_wdata | input | 8 | Write data |
| req_bit | input | 3 | Bit index for bit operations |
| flag_raise | input | 4 | Hardware event per status flag |
| rd_data | output | 8 | Combinational read data |
| bit_flag | output | 1 | Combinational bit-test result |
| err | output | 1 | One-cycle strobe after an illegal request |

## Verification
A wrong translation or legality decision appears in the same cycle: `rd_data` or `bit_flag` disagrees with the value expected for the swept address. It also appears one cycle later as a wrong level on `err`. A corrupted register, for example a bit operation that writes back neighbouring bits or a store that lands on the wrong byte, remains hidden until that register is next read. The bench therefore reads every affected register immediately after each group of writes and bit operations. A lost or stuck status flag shows on the first status read after the raise or the clear.

// File: rtl/iosp_pkg.sv
package iosp_pkg;

    typedef enum logic [2:0] {
        OP_PORT_RD = 3'd0,
        OP_PORT_WR = 3'd1,
        OP_MEM_RD  = 3'd2,
        OP_MEM_WR  = 3'd3,
        OP_BIT_SET = 3'd4,
        OP_BIT_CLR = 3'd5,
        OP_BIT_TST = 3'd6,
        OP_INVALID = 3'd7
    } iosp_op_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_GP   = 2'd1,
        TGT_STAT = 2'd2,
        TGT_EXT  = 2'd3
    } iosp_tgt_e;

    typedef enum logic {
        ST_CLEAN = 1'b0,
        ST_FAULT = 1'b1
    } iosp_st_e;

endpackage

// File: rtl/iosp_addr_map.sv
module iosp_addr_map
    import iosp_pkg::*;
#(
    parameter int AW         = 8,
    parameter int GW         = 2,
    parameter int GP_COUNT   = 4,
    parameter int STAT_IO    = 4,
    parameter int EXT_DADDR  = 96,
    parameter int PORT_SPAN  = 64,
    parameter int BIT_SPAN   = 32,
    parameter int IO_OFFSET  = 32
) (
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    output logic          acc_legal,
    output iosp_tgt_e     acc_tgt,
    output logic [GW-1:0] acc_gp_idx,
    output logic          acc_rd,
    output logic          acc_wr,
    output logic          acc_set,
    output logic          acc_clr,
    output logic          acc_tst
);

    localparam logic [AW:0] PORT_LIM = (AW+1)'(PORT_SPAN);
    localparam logic [AW:0] BIT_LIM  = (AW+1)'(BIT_SPAN);
    localparam logic [AW:0] IO_BASE  = (AW+1)'(IO_OFFSET);
    localparam logic [AW:0] GP_END   = (AW+1)'(IO_OFFSET + GP_COUNT);
    localparam logic [AW:0] STAT_D   = (AW+1)'(IO_OFFSET + STAT_IO);
    localparam logic [AW:0] EXT_D    = (AW+1)'(EXT_DADDR);

    logic [AW:0] addr_w;
    logic [AW:0] daddr;
    logic        space_ok;
    logic        is_mem;
    iosp_op_e    op;

    assign addr_w = {1'b0, req_addr};
    assign op     = iosp_op_e'(req_op);

    // Translate each operation class into a unified data-space address.
    always_comb begin
        space_ok = 1'b0;
        is_mem   = 1'b0;
        daddr    = addr_w;
        unique case (op)
            OP_PORT_RD, OP_PORT_WR: begin
                space_ok = (addr_w < PORT_LIM);
                daddr    = addr_w + IO_BASE;
            end
            OP_MEM_RD, OP_MEM_WR: begin
                space_ok = (addr_w >= IO_BASE);
                is_mem   = 1'b1;
                daddr    = addr_w;
            end
            OP_BIT_SET, OP_BIT_CLR, OP_BIT_TST: begin
                space_ok = (addr_w < BIT_LIM);
                daddr    = addr_w + IO_BASE;
            end
            default: begin
                space_ok = 1'b0;
            end
        endcase
    end

    // Pick the register that owns the unified address.
    always_comb begin
        acc_tgt    = TGT_NONE;
        acc_gp_idx = GW'(daddr - IO_BASE);
        if (space_ok) begin
            if (daddr >= IO_BASE && daddr < GP_END) begin
                acc_tgt = TGT_GP;
            end else if (daddr == STAT_D) begin
                acc_tgt = TGT_STAT;
            end else if (daddr == EXT_D && is_mem) begin
                acc_tgt = TGT_EXT;
            end
        end
    end

    assign acc_legal = req_valid && (acc_tgt != TGT_NONE);
    assign acc_rd    = (op == OP_PORT_RD) || (op == OP_MEM_RD);
    assign acc_wr    = (op == OP_PORT_WR) || (op == OP_MEM_WR);
    assign acc_set   = (op == OP_BIT_SET);
    assign acc_clr   = (op == OP_BIT_CLR);
    assign acc_tst   = (op == OP_BIT_TST);

endmodule

// File: rtl/iosp_gp_bank.sv
module iosp_gp_bank #(
    parameter int DW    = 8,
    parameter int COUNT = 4,
    parameter int IW    = 2,
    parameter int BW    = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                set_en,
    input  logic                clr_en,
    input  logic [IW-1:0]       idx,
    input  logic [BW-1:0]       bit_idx,
    input  logic [DW-1:0]       wdata,
    output logic [COUNT*DW-1:0] regs_flat
);

    for (genvar g = 0; g < COUNT; g++) begin : g_byte
        logic [DW-1:0] q;
        logic          hit;

        assign hit = (idx == IW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (hit) begin
                if (wr_en) begin
                    q <= wdata;
                end else if (set_en) begin
                    q[bit_idx] <= 1'b1;
                end else if (clr_en) begin
                    q[bit_idx] <= 1'b0;
                end
            end
        end

        assign regs_flat[g*DW +: DW] = q;
    end

endmodule

// File: rtl/iosp_w1c_flags.sv
module iosp_w1c_flags #(
    parameter int NFLAGS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_en,
    input  logic [NFLAGS-1:0] clr_mask,
    input  logic [NFLAGS-1:0] raise,
    output logic [NFLAGS-1:0] flags
);

    for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[g] <= 1'b0;
            end else if (raise[g]) begin
                flags[g] <= 1'b1;
            end else if (clr_en && clr_mask[g]) begin
                flags[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/iosp_decoder.sv
module iosp_decoder
    import iosp_pkg::*;
#(
    parameter int DW        = 8,
    parameter int AW        = 8,
    parameter int GP_COUNT  = 4,
    parameter int STAT_IO   = 4,
    parameter int NFLAGS    = 4,
    parameter int EXT_DADDR = 96,
    parameter int PORT_SPAN = 64,
    parameter int BIT_SPAN  = 32,
    parameter int IO_OFFSET = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [$clog2(DW)-1:0] req_bit,
    input  logic [NFLAGS-1:0] flag_raise,
    output logic [DW-1:0]     rd_data,
    output logic              bit_flag,
    output logic              err
);

    localparam int BW = $clog2(DW);
    localparam int GW = (GP_COUNT > 1) ? $clog2(GP_COUNT) : 1;

    logic          acc_legal;
    iosp_tgt_e     acc_tgt;
    logic [GW-1:0] acc_gp_idx;
    logic          acc_rd, acc_wr, acc_set, acc_clr, acc_tst;

    iosp_addr_map #(
        .AW(AW), .GW(GW), .GP_COUNT(GP_COUNT), .STAT_IO(STAT_IO),
        .EXT_DADDR(EXT_DADDR), .PORT_SPAN(PORT_SPAN),
        .BIT_SPAN(BIT_SPAN), .IO_OFFSET(IO_OFFSET)
    ) u_map (
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .acc_legal (acc_legal),
        .acc_tgt   (acc_tgt),
        .acc_gp_idx(acc_gp_idx),
        .acc_rd    (acc_rd),
        .acc_wr    (acc_wr),
        .acc_set   (acc_set),
        .acc_clr   (acc_clr),
        .acc_tst   (acc_tst)
    );

    // General-purpose bytes
    logic                   gp_hit;
    logic [GP_COUNT*DW-1:0] gp_flat;
    logic [DW-1:0]          gp_word [GP_COUNT];

    assign gp_hit = acc_legal && (acc_tgt == TGT_GP);

    iosp_gp_bank #(.DW(DW), .COUNT(GP_COUNT), .IW(GW), .BW(BW)) u_gp (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (gp_hit && acc_wr),
        .set_en   (gp_hit && acc_set),
        .clr_en   (gp_hit && acc_clr),
        .idx      (acc_gp_idx),
        .bit_idx  (req_bit),
        .wdata    (req_wdata),
        .regs_flat(gp_flat)
    );

    for (genvar g = 0; g < GP_COUNT; g++) begin : g_unpack
        assign gp_word[g] = gp_flat[g*DW +: DW];
    end

    // Status flags: a write of one or a bit set clears; a bit clear does nothing.
    logic              stat_hit;
    logic [DW-1:0]     bit_onehot;
    logic [NFLAGS-1:0] stat_clr_mask;
    logic [NFLAGS-1:0] flag_bits;
    logic [DW-1:0]     stat_word;

    assign stat_hit   = acc_legal && (acc_tgt == TGT_STAT);
    assign bit_onehot = DW'(1) << req_bit;

    always_comb begin
        if (acc_wr) begin
            stat_clr_mask = req_wdata[NFLAGS-1:0];
        end else if (acc_set) begin
            stat_clr_mask = bit_onehot[NFLAGS-1:0];
        end else begin
            stat_clr_mask = '0;
        end
    end

    iosp_w1c_flags #(.NFLAGS(NFLAGS)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .clr_en  (stat_hit),
        .clr_mask(stat_clr_mask),
        .raise   (flag_raise),
        .flags   (flag_bits)
    );

    assign stat_word = {{(DW-NFLAGS){1'b0}}, flag_bits};

    // Extended byte, reachable through data space only
    logic [DW-1:0] ext_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q <= '0;
        end else if (acc_legal && acc_tgt == TGT_EXT && acc_wr) begin
            ext_q <= req_wdata;
        end
    end

    // Read path
    logic [DW-1:0] sel_val;

    always_comb begin
        unique case (acc_tgt)
            TGT_GP:   sel_val = gp_word[acc_gp_idx];
            TGT_STAT: sel_val = stat_word;
            TGT_EXT:  sel_val = ext_q;
            default:  sel_val = '0;
        endcase
    end

    assign rd_data  = (acc_legal && acc_rd)  ? sel_val : '0;
    assign bit_flag = (acc_legal && acc_tst) ? sel_val[req_bit] : 1'b0;

    // Fault-strobe state machine
    iosp_st_e st_q, st_d;

    always_comb begin
        unique case (st_q)
            ST_CLEAN: st_d = (req_valid && !acc_legal) ? ST_FAULT : ST_CLEAN;
            ST_FAULT: st_d = (req_valid && !acc_legal) ? ST_FAULT : ST_CLEAN;
            default:  st_d = ST_CLEAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_CLEAN;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (st_q)
            ST_FAULT: err = 1'b1;
            default:  err = 1'b0;
        endcase
    end

endmodule

// File: rtl/iosp_decoder_chk.sv
module iosp_decoder_chk #(
    parameter int DW       = 8,
    parameter int GP_COUNT = 4,
    parameter int NFLAGS   = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   req_valid,
    input logic [DW-1:0]          rd_data,
    input logic                   bit_flag,
    input logic                   err,
    input logic [NFLAGS-1:0]      flag_raise,
    input logic                   acc_legal,
    input logic                   stat_hit,
    input logic                   gp_bitop,
    input logic [GP_COUNT*DW-1:0] gp_flat,
    input logic [NFLAGS-1:0]      flag_bits
);

    p_err_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !acc_legal) |=> err);

    p_err_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !acc_legal) |=> !err);

    p_illegal_keeps_gp_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !acc_legal) |=> $stable(gp_flat));

    p_bitop_single_r6: assert property (@(posedge clk) disable iff (rst)
        gp_bitop |=> ($countones(gp_flat ^ $past(gp_flat)) <= 1));

    p_raise_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (|flag_raise) |=> ((flag_bits & $past(flag_raise)) == $past(flag_raise)));

    p_rsv_zero_r9: assert property (@(posedge clk) disable iff (rst)
        stat_hit |-> (rd_data[DW-1:NFLAGS] == '0));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (rd_data == '0 && !bit_flag));

endmodule

bind iosp_decoder iosp_decoder_chk #(.DW(DW), .GP_COUNT(GP_COUNT), .NFLAGS(NFLAGS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .rd_data   (rd_data),
    .bit_flag  (bit_flag),
    .err       (err),
    .flag_raise(flag_raise),
    .acc_legal (acc_legal),
    .stat_hit  (stat_hit),
    .gp_bitop  (gp_hit && (acc_set || acc_clr)),
    .gp_flat   (gp_flat),
    .flag_bits (flag_bits)
);

// File: tb/iosp_decoder_bench.sv
module iosp_decoder_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = '0;
    logic [7:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic [2:0] req_bit = '0;
    logic [3:0] flag_raise = '0;
    logic [7:0] rd_data;
    logic       bit_flag;
    logic       err;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    int gp_m [4];
    int st_m;
    int ext_m;

    always #2.5 clk = ~clk;

    iosp_decoder u_iosp_decoder (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_bit(req_bit),
        .flag_raise(flag_raise), .rd_data(rd_data), .bit_flag(bit_flag), .err(err)
    );

    task automatic chk(input string req, input int act, input int expv);
        n_run++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    // Expected mapping from R2..R5 and R11: tgt 0 none, 1 gp, 2 status, 3 ext
    function automatic void bmap(input int op, input int a, output bit ok,
                                 output int tgt, output int idx);
        int d;
        d = -1; tgt = 0; idx = 0;
        if (op <= 1) begin
            if (a < 64) d = a + 32;
        end else if (op <= 3) begin
            if (a >= 32) d = a;
        end else if (op <= 6) begin
            if (a < 32) d = a + 32;
        end
        if (d >= 32 && d < 36) begin
            tgt = 1; idx = d - 32;
        end else if (d == 36) begin
            tgt = 2;
        end else if (d == 96 && (op == 2 || op == 3)) begin
            tgt = 3;
        end
        ok = (tgt != 0);
    endfunction

    function automatic int cur(input int tgt, input int idx);
        if (tgt == 1) return gp_m[idx];
        if (tgt == 2) return st_m;
        if (tgt == 3) return ext_m;
        return 0;
    endfunction

    // One request cycle, entered and left at a falling edge.
    task automatic apply(input int op, input int a, input int wd, input int b,
                         input int raise, input string req);
        bit ok;
        int tgt, idx, v, expv, expf;
        bmap(op, a, ok, tgt, idx);
        v = ok ? cur(tgt, idx) : 0;
        req_valid  = 1'b1;
        req_op     = 3'(op);
        req_addr   = 8'(a);
        req_wdata  = 8'(wd);
        req_bit    = 3'(b);
        flag_raise = 4'(raise);
        #1;
        expv = (ok && (op == 0 || op == 2)) ? v : 0;
        expf = (ok && op == 6) ? ((v >> b) & 1) : 0;
        chk({req, " rd_data"}, int'(rd_data), expv);
        chk({req, " bit_flag"}, int'(bit_flag), expf);
        if (ok) begin
            case (op)
                1, 3: begin
                    if (tgt == 1) gp_m[idx] = wd & 255;
                    else if (tgt == 2) st_m = st_m & ~(wd & 15);
                    else ext_m = wd & 255;
                end
                4: begin
                    if (tgt == 1) gp_m[idx] = gp_m[idx] | (1 << b);
                    else if (tgt == 2 && b < 4) st_m = st_m & ~(1 << b);
                end
                5: begin
                    if (tgt == 1) gp_m[idx] = gp_m[idx] & ~(1 << b);
                end
                default: ;
            endcase
        end
        st_m = st_m | (raise & 15);
        @(negedge clk);
        chk({req, " err"}, int'(err), ok ? 0 : 1);
        req_valid  = 1'b0;
        flag_raise = '0;
    endtask

    task automatic idle(input int raise, input string req);
        req_valid  = 1'b0;
        flag_raise = 4'(raise);
        req_op     = 3'd6;
        #1;
        chk({req, " idle rd_data"}, int'(rd_data), 0);
        chk({req, " idle bit_flag"}, int'(bit_flag), 0);
        st_m = st_m | (raise & 15);
        @(negedge clk);
        chk({req, " idle err"}, int'(err), 0);
        flag_raise = '0;
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < 5; i++) apply(0, i, 0, 0, 0, req);
        apply(2, 96, 0, 0, 0, req);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) gp_m[i] = 0;
        st_m = 0;
        ext_m = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 err after reset", int'(err), 0);
        read_all("R1 reset value");

        // Port writes, read back through data space and port form
        for (int i = 0; i < 4; i++) apply(1, i, 8'h3C ^ (i * 37), 0, 0, "R2 port write");
        for (int i = 0; i < 4; i++) apply(2, 32 + i, 0, 0, 0, "R3 load alias");
        for (int i = 0; i < 4; i++) apply(3, 32 + i, 8'hC1 + i * 11, 0, 0, "R3 store alias");
        read_all("R2 port readback");

        // Extended byte
        apply(3, 96, 8'h9E, 0, 0, "R4 ext store");
        apply(2, 96, 0, 0, 0, "R4 ext load");
        apply(1, 96, 8'h11, 0, 0, "R4 port to ext illegal");
        apply(2, 96, 0, 0, 0, "R4 ext unchanged");

        // Address sweeps per operation class
        for (int a = 0; a < 256; a++) apply(0, a, 0, 0, 0, "R11 port read sweep");
        for (int a = 0; a < 256; a++) apply(2, a, 0, 0, 0, "R12 load sweep");
        for (int a = 0; a < 256; a++) apply(6, a, 0, a & 7, 0, "R5 bit test sweep");
        for (int a = 5; a < 256; a++) apply(1, a, 8'hFF, 0, 0, "R11 port write illegal");
        for (int a = 0; a < 256; a++) begin
            if (!(a >= 32 && a < 37) && a != 96) apply(3, a, 8'h5A, 0, 0, "R11 store illegal");
        end
        for (int a = 32; a < 256; a += 3) apply(4, a, 0, 1, 0, "R5 bit set out of range");
        for (int a = 32; a < 256; a += 3) apply(5, a, 0, 2, 0, "R5 bit clear out of range");
        apply(7, 0, 8'hFF, 0, 0, "R11 invalid op");
        read_all("R11 registers untouched");

        // Exhaustive bit set/clear on general-purpose bytes
        for (int r = 0; r < 4; r++) begin
            apply(1, r, 8'h96 ^ (r * 29), 0, 0, "R6 seed");
            for (int b = 0; b < 8; b++) begin
                apply(4, r, 0, b, 0, "R6 bit set");
                apply(0, r, 0, 0, 0, "R6 after set");
                apply(5, r, 0, (b + 3) & 7, 0, "R6 bit clear");
                apply(0, r, 0, 0, 0, "R6 after clear");
            end
            for (int b = 0; b < 8; b++) apply(6, r, 0, b, 0, "R10 bit test");
        end

        // Status flags
        idle(4'hF, "R8 raise all");
        apply(0, 4, 0, 0, 0, "R8 flags set");
        apply(1, 4, 8'h05, 0, 0, "R7 write-one clear");
        apply(0, 4, 0, 0, 0, "R7 after w1c");
        idle(4'hF, "R8 re-raise");
        apply(5, 4, 0, 1, 0, "R7 bit clear no effect");
        apply(0, 4, 0, 0, 0, "R7 after bit clear");
        apply(4, 4, 0, 2, 0, "R7 bit set clears one");
        apply(0, 4, 0, 0, 0, "R7 after bit set");
        apply(4, 4, 0, 6, 0, "R9 bit set reserved");
        apply(3, 36, 8'hF0, 0, 0, "R9 write reserved");
        apply(2, 36, 0, 0, 0, "R9 reserved read zero");
        for (int b = 0; b < 8; b++) apply(6, 4, 0, b, 0, "R10 status test");
        apply(3, 36, 8'h01, 0, 4'h1, "R8 raise beats clear");
        apply(0, 4, 0, 0, 0, "R8 flag kept");
        apply(1, 4, 8'hFF, 0, 0, "R7 clear all");
        apply(0, 4, 0, 0, 0, "R7 all clear");
        idle(0, "R10 idle");

        // Reset again
        req_valid = 1'b1; req_op = 3'd7;
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) gp_m[i] = 0;
        st_m = 0; ext_m = 0;
        chk("R1 err cleared by reset", int'(err), 0);
        read_all("R1 second reset");

        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule